// File: doc/BRIEF.md
# Programmable Multi-Line Edge Detector

This block samples a wide bus of independent lines once per clock. It compares each line with the sample taken one clock earlier and reports a chosen kind of transition for that line: a low-to-high change, a high-to-low change, or any change. Each line has its own 2-bit mode field. The mode fields are packed sixteen to a 32-bit control word. A bank of enable words decides which lines may report at all.

Software configures the block through a plain word-addressed write/read port. A control word can be written whole. A single line can also be retuned in two writes: the first loads a line number into a selector register, and the second writes a mode into a value register. The value write changes only the selected line's field, so two agents that each tune their own lines do not need a read-modify-write and do not clobber each other.

An instance may build fewer control words than the address map reserves. Writes to the missing slots are accepted and have no effect. The lines those slots would cover stay silent.

The outputs are a registered per-line event vector and a flag that is the OR of that vector.

Top module: `edgemon`

## Requirements
- R1: Mode field encoding: 2'b00 reports a low-to-high change, 2'b01 reports a high-to-low change, 2'b10 reports any change, and 2'b11 reports nothing.
- R2: The mode field of line n is held in the control word at word address n/16 (addresses 0x00 to 0x0F), at bits [2*(n mod 16)+1 : 2*(n mod 16)]. With line 7 set to 01 and line 8 set to 10, the word at address 0x00 reads 0x00024000.
- R3: The enable words sit at word addresses 0x10 to 0x17. Bit n mod 32 of the word at 0x10 + n/32 enables line n. A line whose enable bit is 0 never raises its event bit.
- R4: Writing the selector register at address 0x18 loads a line number from bits [7:0]; reading it returns that number. A following write to the value register at 0x19 replaces only the selected line's field with bits [1:0] and leaves every other field unchanged. Reading 0x19 returns the selected line's field in bits [1:0].
- R5: Suppose a line changes, that change is sampled at clock edge k, and the line's mode and enable call for a report. Then its event bit is 1 from edge k until edge k+1, and it is 0 again after edge k+1 if the line holds steady. No event is raised on the first edge after reset.
- R6: Reset clears every mode field, every enable bit and the event outputs, so nothing is reported until software sets an enable bit.
- R7: With parameter CTRL_IMPL set to fewer than 16, the control words at addresses CTRL_IMPL to 0x0F always read 0 and ignore writes. Reading 0x19 with a line in that range returns 0. Lines in that range never raise an event, whatever their enable bit says.
- R8: any_evt_o is 1 exactly when at least one bit of evt_o is 1 in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Word address for both writes and reads |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr (combinational) |
| line_i | input | 256 | Watched lines |
| evt_o | output | 256 | Per-line event pulses, registered |
| any_evt_o | output | 1 | OR of evt_o |

## Verification
A register write is captured on one rising edge and is visible at reg_rdata straight after it, because the read path is combinational. The bench therefore writes on one falling edge and reads on the next. A line value driven on a falling edge is sampled on the following rising edge, and that sample is compared with the previous one. The resulting event is registered on that same edge, so each event check comes one falling edge after the second of two line values. The pulse-width checks look again one falling edge later, with the lines held steady. The reporting conditions are mode, enable, and implemented slot. Each is swept through a table, in which every entry sets up its own line through the selector and value path before it drives a transition.

// File: rtl/edgemon_pkg.sv
package edgemon_pkg;

   typedef enum logic [1:0] {
      EM_RISE = 2'b00,
      EM_FALL = 2'b01,
      EM_BOTH = 2'b10,
      EM_OFF  = 2'b11
   } em_mode_e;

   localparam int unsigned EM_ADDR_W = 6;

   localparam logic [EM_ADDR_W-1:0] EM_CTRL_BASE = 6'h00;
   localparam logic [EM_ADDR_W-1:0] EM_MASK_BASE = 6'h10;
   localparam logic [EM_ADDR_W-1:0] EM_SEL_ADDR  = 6'h18;
   localparam logic [EM_ADDR_W-1:0] EM_VAL_ADDR  = 6'h19;

   function automatic logic em_hit(input logic [1:0] mode, input logic prev, input logic cur);
      logic up;
      logic down;
      up   = cur & ~prev;
      down = prev & ~cur;
      case (em_mode_e'(mode))
         EM_RISE: return up;
         EM_FALL: return down;
         EM_BOTH: return up | down;
         default: return 1'b0;
      endcase
   endfunction

endpackage

// File: rtl/edgemon_regs.sv
module edgemon_regs
   import edgemon_pkg::*;
#(
   parameter int unsigned LINES     = 256,
   parameter int unsigned REG_W     = 32,
   parameter int unsigned CTRL_IMPL = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   we,
   input  logic [EM_ADDR_W-1:0]   addr,
   input  logic [REG_W-1:0]       wdata,
   output logic [REG_W-1:0]       rdata,
   output logic [2*LINES-1:0]     mode_o,
   output logic [LINES-1:0]       mask_o
);

   localparam int unsigned LPR        = REG_W / 2;
   localparam int unsigned LPR_W      = $clog2(LPR);
   localparam int unsigned CTRL_SLOTS = LINES / LPR;
   localparam int unsigned MASK_REGS  = LINES / REG_W;
   localparam int unsigned IDX_W      = $clog2(LINES);
   localparam int unsigned SLOT_W     = IDX_W - LPR_W;
   localparam logic [2*LINES-1:0] FIELD_ONE = {{(2*LINES-2){1'b0}}, 2'b11};

   logic [IDX_W-1:0]  sel_q;
   logic [SLOT_W-1:0] sel_slot;
   logic [LPR_W-1:0]  sel_pos;
   logic              val_we;

   assign sel_slot = sel_q[IDX_W-1:LPR_W];
   assign sel_pos  = sel_q[LPR_W-1:0];
   assign val_we   = we && (addr == EM_VAL_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            sel_q <= '0;
      else if (we && addr == EM_SEL_ADDR)    sel_q <= wdata[IDX_W-1:0];
   end

   for (genvar s = 0; s < CTRL_SLOTS; s++) begin : g_slot
      if (s < CTRL_IMPL) begin : g_impl
         logic [REG_W-1:0] word_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               word_q <= '0;
            else if (we && addr == EM_CTRL_BASE + EM_ADDR_W'(s))
               word_q <= wdata;
            else if (val_we && sel_slot == SLOT_W'(s))
               word_q[{sel_pos, 1'b0} +: 2] <= wdata[1:0];
         end
         assign mode_o[s*REG_W +: REG_W] = word_q;
      end else begin : g_absent
         assign mode_o[s*REG_W +: REG_W] = '1;
      end
   end

   for (genvar m = 0; m < MASK_REGS; m++) begin : g_mask
      logic [REG_W-1:0] word_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                       word_q <= '0;
         else if (we && addr == EM_MASK_BASE + EM_ADDR_W'(m)) word_q <= wdata;
      end
      assign mask_o[m*REG_W +: REG_W] = word_q;
   end

   always_comb begin
      rdata = '0;
      for (int s = 0; s < int'(CTRL_IMPL); s++)
         if (addr == EM_CTRL_BASE + EM_ADDR_W'(s)) rdata = mode_o[s*REG_W +: REG_W];
      for (int m = 0; m < int'(MASK_REGS); m++)
         if (addr == EM_MASK_BASE + EM_ADDR_W'(m)) rdata = mask_o[m*REG_W +: REG_W];
      if (addr == EM_SEL_ADDR) rdata = REG_W'(sel_q);
      if (addr == EM_VAL_ADDR && 32'(sel_slot) < CTRL_IMPL)
         rdata = REG_W'(mode_o[{sel_q, 1'b0} +: 2]);
   end

   // R4: a value write may touch only the selected line's field
   p_value_write_local_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $past(we && addr == EM_VAL_ADDR) |->
         ((mode_o ^ $past(mode_o)) & ~(FIELD_ONE << {$past(sel_q), 1'b0})) == '0);

endmodule

// File: rtl/edgemon_detect.sv
module edgemon_detect
   import edgemon_pkg::*;
#(
   parameter int unsigned LINES = 256
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [LINES-1:0]   line_i,
   input  logic [2*LINES-1:0] mode_i,
   input  logic [LINES-1:0]   mask_i,
   output logic [LINES-1:0]   evt_o
);

   logic [LINES-1:0] prev_q;
   logic [LINES-1:0] hit;
   logic             armed_q;

   for (genvar i = 0; i < LINES; i++) begin : g_line
      assign hit[i] = em_hit(mode_i[2*i +: 2], prev_q[i], line_i[i]);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q  <= '0;
         armed_q <= 1'b0;
         evt_o   <= '0;
      end else begin
         prev_q  <= line_i;
         armed_q <= 1'b1;
         evt_o   <= hit & mask_i & {LINES{armed_q}};
      end
   end

   // R3: a disabled line cannot report
   p_masked_silent_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_o & ~$past(mask_i)) == '0);

   // R5: the first edge after reset never reports
   p_quiet_after_reset_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(armed_q) |-> evt_o == '0);

endmodule

// File: rtl/edgemon.sv
module edgemon
   import edgemon_pkg::*;
#(
   parameter int unsigned LINES     = 256,
   parameter int unsigned REG_W     = 32,
   parameter int unsigned CTRL_IMPL = 16
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 reg_we,
   input  logic [5:0]           reg_addr,
   input  logic [31:0]          reg_wdata,
   output logic [31:0]          reg_rdata,
   input  logic [255:0]         line_i,
   output logic [255:0]         evt_o,
   output logic                 any_evt_o
);

   localparam int unsigned CTRL_SLOTS = LINES / (REG_W / 2);

   if (REG_W != 32) begin : g_bad_width
      $error("edgemon: REG_W must be 32");
   end
   if (LINES != 256) begin : g_bad_lines
      $error("edgemon: LINES must be 256 to match the address map");
   end
   if (CTRL_IMPL < 1 || CTRL_IMPL > CTRL_SLOTS) begin : g_bad_impl
      $error("edgemon: CTRL_IMPL out of range");
   end

   logic [2*LINES-1:0] mode_w;
   logic [LINES-1:0]   mask_w;

   edgemon_regs #(
      .LINES     (LINES),
      .REG_W     (REG_W),
      .CTRL_IMPL (CTRL_IMPL)
   ) u_regs (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (reg_we),
      .addr   (reg_addr),
      .wdata  (reg_wdata),
      .rdata  (reg_rdata),
      .mode_o (mode_w),
      .mask_o (mask_w)
   );

   edgemon_detect #(
      .LINES (LINES)
   ) u_detect (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (line_i),
      .mode_i (mode_w),
      .mask_i (mask_w),
      .evt_o  (evt_o)
   );

   assign any_evt_o = |evt_o;

   // R1: every reported line changed between its last two samples
   p_edge_needs_change_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_o & ~($past(line_i) ^ $past(line_i, 2))) == '0);

endmodule

// File: tb/test_edgemon.sv
module test_edgemon;
   import edgemon_pkg::*;

   localparam int IMPL = 15;
   // entry: {mode[1:0], enable, first value, second value, expected event}
   localparam logic [5:0] VECS [12] = '{
      6'b00_1_0_1_1, 6'b00_1_1_0_0, 6'b01_1_1_0_1, 6'b01_1_0_1_0,
      6'b10_1_0_1_1, 6'b10_1_1_0_1, 6'b10_1_1_1_0, 6'b11_1_0_1_0,
      6'b11_1_1_0_0, 6'b00_0_0_1_0, 6'b01_0_1_0_0, 6'b00_1_1_1_0
   };

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         we = 1'b0;
   logic [5:0]   addr = '0;
   logic [31:0]  wdata = '0;
   logic [31:0]  rdata;
   logic [255:0] lines = '0;
   logic [255:0] evt;
   logic         any;
   int           checks = 0;
   int           errors = 0;

   always #4 clk = ~clk;

   edgemon #(.CTRL_IMPL(IMPL)) i_edgemon (
      .clk(clk), .rst_n(rst_n), .reg_we(we), .reg_addr(addr), .reg_wdata(wdata),
      .reg_rdata(rdata), .line_i(lines), .evt_o(evt), .any_evt_o(any)
   );

   task automatic chk(input string req, input logic [255:0] act, input logic [255:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      we = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      we = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [5:0] a, input logic [31:0] exp);
      addr = a;
      #1;
      chk(req, 256'(rdata), 256'(exp));
   endtask

   task automatic apply(input logic [255:0] v);
      @(negedge clk);
      lines = v;
   endtask

   initial begin
      #(8 * 150000);
      errors++;
      $display("FAIL watchdog expired actual running expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R6: reset state
      chk("R6 evt after reset", evt, '0);
      chk("R8 any after reset", 256'(any), '0);
      rd_chk("R6 ctrl0 reset", 6'h00, 32'h0);
      rd_chk("R6 mask0 reset", 6'h10, 32'h0);
      apply('1);
      @(negedge clk);
      chk("R6 all lines masked after reset", evt, '0);
      apply('0);

      // R1 R3 R4 R5: table sweep, one line per entry
      for (int k = 0; k < 12; k++) begin
         int ln;
         logic [255:0] one;
         ln = 5 + k * 19;
         one = 256'(1) << ln;
         wr(EM_SEL_ADDR, 32'(ln));
         wr(EM_VAL_ADDR, 32'(VECS[k][5:4]));
         wr(EM_MASK_BASE + 6'(ln / 32), 32'(VECS[k][3]) << (ln % 32));
         apply(VECS[k][2] ? one : '0);
         apply(VECS[k][1] ? one : '0);
         @(negedge clk);
         chk($sformatf("R1 R3 R5 vector %0d evt", k), evt, VECS[k][0] ? one : '0);
         chk($sformatf("R8 vector %0d any", k), 256'(any), 256'(VECS[k][0]));
      end
      apply('0);

      // R2: field placement through the value path
      wr(EM_SEL_ADDR, 32'd7);
      wr(EM_VAL_ADDR, 32'd1);
      wr(EM_SEL_ADDR, 32'd8);
      wr(EM_VAL_ADDR, 32'd2);
      rd_chk("R2 ctrl0 packed", 6'h00, 32'h0002_4000);
      rd_chk("R4 value readback", EM_VAL_ADDR, 32'd2);

      // R4: value write leaves neighbours alone
      wr(6'h02, 32'hFFFF_FFFF);
      wr(EM_SEL_ADDR, 32'd33);
      wr(EM_VAL_ADDR, 32'd0);
      rd_chk("R4 ctrl2 local update", 6'h02, 32'hFFFF_FFF3);
      rd_chk("R4 selector readback", EM_SEL_ADDR, 32'd33);

      // R7: unimplemented slot
      wr(6'h0F, 32'hFFFF_FFFF);
      rd_chk("R7 absent slot reads zero", 6'h0F, 32'h0);
      wr(EM_MASK_BASE + 6'd7, 32'hFFFF_FFFF);
      wr(EM_SEL_ADDR, 32'd250);
      wr(EM_VAL_ADDR, 32'd2);
      rd_chk("R7 absent field reads zero", EM_VAL_ADDR, 32'h0);
      apply(256'(1) << 250);
      @(negedge clk);
      chk("R7 absent line silent", evt, '0);

      // R5 R8: pulse width and flag on two lines
      wr(6'h00, 32'h0000_0020);
      wr(EM_MASK_BASE, 32'h0000_0006);
      apply(256'h6);
      @(negedge clk);
      chk("R5 two rising lines", evt, 256'h6);
      chk("R8 any on events", 256'(any), 256'(1));
      @(negedge clk);
      chk("R5 pulse ends after one cycle", evt, '0);
      chk("R8 any clear", 256'(any), '0);
      apply('0);
      @(negedge clk);
      chk("R1 fall seen only by toggle line", evt, 256'h4);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule